// File: doc/BRIEF.md
# Single-Bank Graphics DRAM Command Decoder and Bank Timer

This block watches the command pins of a synchronous graphics DRAM on behalf of one bank. On every clock edge it classifies the command on the pins as activate, precharge, read, read with auto-precharge, write or no-operation. It then keeps that bank's state (idle, open, or closing after an auto-precharging read) and judges whether the command is legal at that moment. A column command must wait a programmable number of cycles after the row was opened. A read that auto-precharges blocks every further command to the bank for the row-precharge time plus the burst length, after which the bank is idle again.

Every output is registered: a command sampled at clock edge k shows up on the outputs after edge k. An illegal or premature command raises a one-cycle error pulse and does not change the bank's state. Both timing limits are parameters in clock cycles. The burst length comes from a mode input. When that input selects full-page bursts, the auto-precharge request is dropped and the read leaves the row open.

Top module: `sgram_bank_cmd`

## Requirements
- R1: With the pins written as {rasN,casN,weN}, the block reports on cmdKind the class of the command for this bank: 011 is activate (code 1), 010 is precharge (code 2), 101 with dsf low is read (code 3), or read with auto-precharge (code 4) when a9 is high, and 100 with dsf low is write (code 5). Every other pattern, including any column pattern with dsf high, is no-operation (code 0) and never raises an error.
- R2: An activate while the bank is idle sets bankOpen from the next cycle. An activate while the bank is open or locked is an error.
- R3: A read or write is legal only while the bank is open and at least TRCD cycles after the accepted activate. An activate at edge T allows a column command at edge T+TRCD and rejects one at edge T+TRCD-1. A rejected column command gives no colStrobe.
- R4: An accepted read or write raises colStrobe for one cycle, sets colIsWrite to 1 for a write and 0 for a read, and presents colAddr on colAddrQ.
- R5: burstSel selects the burst length: 0 is 1, 1 is 2, 2 is 4, 3 is 8, and 4 to 7 are full-page. An accepted read with auto-precharge at edge T, with a burst that is not full-page, closes the bank and raises lockBusy. Any command at edges T+1 to T+TRP+BL-1 is an error. From edge T+TRP+BL-1 the bank is idle, so a command at edge T+TRP+BL is judged against the idle state.
- R6: With a full-page burst, a read with auto-precharge is accepted as a plain read: the bank stays open, lockBusy stays low, and a column command on the next edge is legal.
- R7: A precharge closes an open bank. A precharge to an idle bank is legal and leaves it idle. A precharge during the lockout is an error.
- R8: cmdErr is high for exactly the cycle after each illegal command. A rejected command leaves bankOpen unchanged, and the lockout timer keeps running through it.
- R9: A write with a9 high is an ordinary write: it is accepted, the bank stays open, and no lockout starts.
- R10: After reset the bank is idle, and cmdKind, cmdErr, bankOpen, lockBusy and colStrobe are all 0.
- R11: A command whose bank select differs from BANK_ID is a no-operation for this bank: no error and no state change. The one exception is a precharge with a9 high, which closes this bank too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe command pin, active low |
| casN | input | 1 | Column strobe command pin, active low |
| weN | input | 1 | Write enable command pin, active low |
| dsf | input | 1 | Special-function pin; high turns column patterns into no-operation |
| bankSel | input | 1 | Bank select bit of the command |
| a9 | input | 1 | Auto-precharge request on reads, all-bank flag on precharge |
| colAddr | input | COL_W | Column address carried by read and write |
| burstSel | input | 3 | Burst length selection from the mode setting |
| cmdKind | output | 3 | Class of the command sampled at the last edge |
| cmdErr | output | 1 | One-cycle pulse for an illegal or premature command |
| bankOpen | output | 1 | Bank holds an open row |
| lockBusy | output | 1 | Auto-precharge lockout in progress |
| colStrobe | output | 1 | One-cycle pulse for an accepted column command |
| colIsWrite | output | 1 | Accepted column command was a write |
| colAddrQ | output | COL_W | Column address of the last accepted column command |

## Verification
Two things can happen on the same edge: the lockout timer returning the bank to idle, and a new command being judged. The bench places an activate on the last locked edge, where it must fail while lockBusy drops in the same update. It then places another activate on the very next edge, where it must open the bank. The same boundary is tested against the activate-to-column delay, with a write one edge early and then one exactly on time. This catches an off-by-one in either counter or a wrong order between expiry and judgement.

// File: rtl/sgram_bank_pkg.sv
package sgram_bank_pkg;

  typedef enum logic [2:0] {
    KIND_NOP = 3'd0,
    KIND_ACT = 3'd1,
    KIND_PRE = 3'd2,
    KIND_RD  = 3'd3,
    KIND_RDA = 3'd4,
    KIND_WR  = 3'd5
  } cmdKind_e;

  typedef enum logic [1:0] {
    BANK_IDLE = 2'd0,
    BANK_OPEN = 2'd1,
    BANK_LOCK = 2'd2
  } bankState_e;

  // strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic loadRcd;   // row opened: restart activate-to-column delay
    logic loadLock;  // auto-precharge read accepted: start lockout
    logic latchCol;  // column command accepted: capture address
  } ctrlStrobe_t;

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_bank_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  input  logic     dsf,
  input  logic     bankSel,
  input  logic     a9,
  output cmdKind_e kind
);

  localparam logic BANK_BIT = 1'(BANK_ID);

  logic hit;
  assign hit = (bankSel == BANK_BIT);

  always_comb begin
    kind = KIND_NOP;
    unique case ({rasN, casN, weN})
      3'b011: if (hit) kind = KIND_ACT;
      3'b010: if (hit || a9) kind = KIND_PRE;
      3'b101: if (hit && !dsf) kind = a9 ? KIND_RDA : KIND_RD;
      3'b100: if (hit && !dsf) kind = KIND_WR;
      default: kind = KIND_NOP;
    endcase
  end

endmodule

// File: rtl/sgram_bank_timers.sv
module sgram_bank_timers
  import sgram_bank_pkg::*;
#(
  parameter int TRCD  = 3,
  parameter int TRP   = 2,
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        burstSel,
  input  logic [COL_W-1:0]  colAddr,
  output logic              rcdDone,
  output logic              lockLast,
  output logic              fullPage,
  output logic [COL_W-1:0]  colAddrQ
);

  localparam int MAX_BL = 8;
  localparam int RCD_W  = $clog2(TRCD + 1);
  localparam int LOCK_W = $clog2(TRP + MAX_BL + 1);

  logic [RCD_W-1:0]  rcdCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic [LOCK_W-1:0] burstLen;

  always_comb begin
    unique case (burstSel)
      3'd0:    burstLen = LOCK_W'(1);
      3'd1:    burstLen = LOCK_W'(2);
      3'd2:    burstLen = LOCK_W'(4);
      3'd3:    burstLen = LOCK_W'(MAX_BL);
      default: burstLen = '0;
    endcase
  end

  assign fullPage = burstSel[2];

  // counts down to zero; a column command is allowed once it is zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcdCnt <= '0;
    end else if (strobe.loadRcd) begin
      rcdCnt <= RCD_W'(TRCD - 1);
    end else if (rcdCnt != '0) begin
      rcdCnt <= rcdCnt - 1'b1;
    end
  end

  assign rcdDone = (rcdCnt == '0);

  // lockout length TRP + BL; the FSM leaves lockout when the count is 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (strobe.loadLock) begin
      lockCnt <= LOCK_W'(TRP) + burstLen - 1'b1;
    end else if (lockCnt != '0) begin
      lockCnt <= lockCnt - 1'b1;
    end
  end

  assign lockLast = (lockCnt == LOCK_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colAddrQ <= '0;
    end else if (strobe.latchCol) begin
      colAddrQ <= colAddr;
    end
  end

endmodule

// File: rtl/sgram_bank_ctrl.sv
module sgram_bank_ctrl
  import sgram_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cmdKind_e    kind,
  input  logic        rcdDone,
  input  logic        lockLast,
  input  logic        fullPage,
  output ctrlStrobe_t strobe,
  output bankState_e  bankState,
  output cmdKind_e    kindQ,
  output logic        errQ,
  output logic        colStrobeQ,
  output logic        colWriteQ
);

  bankState_e nextState;
  logic       errNow;
  logic       colNow;

  always_comb begin
    strobe    = '0;
    errNow    = 1'b0;
    colNow    = 1'b0;
    // lockout expiry runs regardless of the command being judged
    nextState = (bankState == BANK_LOCK && lockLast) ? BANK_IDLE : bankState;
    unique case (kind)
      KIND_ACT: begin
        if (bankState == BANK_IDLE) begin
          nextState      = BANK_OPEN;
          strobe.loadRcd = 1'b1;
        end else begin
          errNow = 1'b1;
        end
      end
      KIND_PRE: begin
        if (bankState == BANK_LOCK) errNow = 1'b1;
        else nextState = BANK_IDLE;
      end
      KIND_RD, KIND_RDA, KIND_WR: begin
        if (bankState != BANK_OPEN || !rcdDone) begin
          errNow = 1'b1;
        end else begin
          colNow          = 1'b1;
          strobe.latchCol = 1'b1;
          if (kind == KIND_RDA && !fullPage) begin
            nextState       = BANK_LOCK;
            strobe.loadLock = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankState  <= BANK_IDLE;
      kindQ      <= KIND_NOP;
      errQ       <= 1'b0;
      colStrobeQ <= 1'b0;
      colWriteQ  <= 1'b0;
    end else begin
      bankState  <= nextState;
      kindQ      <= kind;
      errQ       <= errNow;
      colStrobeQ <= colNow;
      if (colNow) colWriteQ <= (kind == KIND_WR);
    end
  end

endmodule

// File: rtl/sgram_bank_cmd.sv
module sgram_bank_cmd
  import sgram_bank_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int TRCD    = 3,
  parameter int TRP     = 2,
  parameter int COL_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             dsf,
  input  logic             bankSel,
  input  logic             a9,
  input  logic [COL_W-1:0] colAddr,
  input  logic [2:0]       burstSel,
  output logic [2:0]       cmdKind,
  output logic             cmdErr,
  output logic             bankOpen,
  output logic             lockBusy,
  output logic             colStrobe,
  output logic             colIsWrite,
  output logic [COL_W-1:0] colAddrQ
);

  cmdKind_e    kind;
  cmdKind_e    kindQ;
  ctrlStrobe_t strobe;
  bankState_e  bankState;
  logic        rcdDone;
  logic        lockLast;
  logic        fullPage;

  sgram_cmd_decode #(.BANK_ID(BANK_ID)) i_decode (
    .rasN(rasN), .casN(casN), .weN(weN), .dsf(dsf),
    .bankSel(bankSel), .a9(a9), .kind(kind)
  );

  sgram_bank_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .kind(kind), .rcdDone(rcdDone),
    .lockLast(lockLast), .fullPage(fullPage), .strobe(strobe),
    .bankState(bankState), .kindQ(kindQ), .errQ(cmdErr),
    .colStrobeQ(colStrobe), .colWriteQ(colIsWrite)
  );

  sgram_bank_timers #(.TRCD(TRCD), .TRP(TRP), .COL_W(COL_W)) i_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstSel(burstSel),
    .colAddr(colAddr), .rcdDone(rcdDone), .lockLast(lockLast),
    .fullPage(fullPage), .colAddrQ(colAddrQ)
  );

  assign cmdKind  = kindQ;
  assign bankOpen = (bankState == BANK_OPEN);
  assign lockBusy = (bankState == BANK_LOCK);

endmodule

// File: rtl/sgram_bank_cmd_chk.sv
module sgram_bank_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cmdKind,
  input logic       cmdErr,
  input logic       bankOpen,
  input logic       lockBusy,
  input logic       colStrobe
);

  AST_ERR_NO_COL: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> !colStrobe); // R3

  AST_COL_FROM_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe |-> $past(bankOpen)); // R3

  AST_OPEN_BY_ACT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bankOpen) |-> cmdKind == 3'd1); // R2

  AST_LOCK_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockBusy) |-> colStrobe && cmdKind == 3'd4); // R5

  AST_LOCK_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    lockBusy |-> !bankOpen); // R5

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr && !$past(lockBusy) |-> $stable(bankOpen)); // R8

endmodule

bind sgram_bank_cmd sgram_bank_cmd_chk i_chk (
  .clk(clk), .rstN(rstN), .cmdKind(cmdKind), .cmdErr(cmdErr),
  .bankOpen(bankOpen), .lockBusy(lockBusy), .colStrobe(colStrobe)
);

// File: tb/test_sgram_bank_cmd.sv
module test_sgram_bank_cmd;

  localparam int TRCD = 3;
  localparam int TRP  = 2;
  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_PRE = 3'b010,
                         P_RD  = 3'b101, P_WR  = 3'b100, P_REF = 3'b001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, dsf = 1'b0, bankSel = 1'b0, a9 = 1'b0;
  logic [7:0] colAddr = '0;
  logic [2:0] burstSel = 3'd2;
  logic [2:0] cmdKind;
  logic cmdErr, bankOpen, lockBusy, colStrobe, colIsWrite;
  logic [7:0] colAddrQ;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sgram_bank_cmd #(.BANK_ID(0), .TRCD(TRCD), .TRP(TRP), .COL_W(8)) i_sgram_bank_cmd (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .dsf(dsf),
    .bankSel(bankSel), .a9(a9), .colAddr(colAddr), .burstSel(burstSel),
    .cmdKind(cmdKind), .cmdErr(cmdErr), .bankOpen(bankOpen), .lockBusy(lockBusy),
    .colStrobe(colStrobe), .colIsWrite(colIsWrite), .colAddrQ(colAddrQ)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample, return at the next falling edge
  task automatic doCmd(input logic [2:0] pins, input logic d, input logic bk,
                       input logic ap, input logic [7:0] col);
    {rasN, casN, weN} = pins;
    dsf = d; bankSel = bk; a9 = ap; colAddr = col;
    @(negedge clk);
    {rasN, casN, weN} = P_NOP;
    dsf = 1'b0; bankSel = 1'b0; a9 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10", "bankOpen", bankOpen, 0);
    chk("R10", "lockBusy", lockBusy, 0);
    chk("R10", "cmdErr", cmdErr, 0);
    chk("R10", "colStrobe", colStrobe, 0);
    chk("R10", "cmdKind", cmdKind, 0);
  endtask

  task automatic t_decode;
    doCmd(P_REF, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "refresh kind", cmdKind, 0);
    chk("R1", "refresh err", cmdErr, 0);
    doCmd(P_RD, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R1", "dsf read kind", cmdKind, 0);
    chk("R1", "dsf read err", cmdErr, 0);
    doCmd(P_NOP, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1", "nop kind", cmdKind, 0);
  endtask

  task automatic t_activate;
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R2", "act kind", cmdKind, 1);
    chk("R2", "act opens", bankOpen, 1);
    chk("R2", "act err", cmdErr, 0);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R2", "second act err", cmdErr, 1);
    chk("R8", "open kept after err", bankOpen, 1);
    doCmd(P_NOP, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R8", "err one cycle", cmdErr, 0);
  endtask

  task automatic t_rcd;
    doCmd(P_PRE, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7", "pre kind", cmdKind, 2);
    chk("R7", "pre closes", bankOpen, 0);
    doCmd(P_RD, 1'b0, 1'b0, 1'b0, 8'h11);
    chk("R3", "read idle err", cmdErr, 1);
    chk("R3", "read idle strobe", colStrobe, 0);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    idle(TRCD - 2);
    doCmd(P_WR, 1'b0, 1'b0, 1'b0, 8'h22);
    chk("R3", "early write err", cmdErr, 1);
    chk("R3", "early write strobe", colStrobe, 0);
    doCmd(P_WR, 1'b0, 1'b0, 1'b0, 8'h3C);
    chk("R3", "on-time write err", cmdErr, 0);
    chk("R4", "write strobe", colStrobe, 1);
    chk("R4", "write flag", colIsWrite, 1);
    chk("R4", "write addr", colAddrQ, 8'h3C);
    doCmd(P_NOP, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R4", "strobe one cycle", colStrobe, 0);
  endtask

  task automatic t_read_write_a9;
    doCmd(P_RD, 1'b0, 1'b0, 1'b0, 8'hA5);
    chk("R1", "read kind", cmdKind, 3);
    chk("R4", "read flag", colIsWrite, 0);
    chk("R4", "read addr", colAddrQ, 8'hA5);
    doCmd(P_WR, 1'b0, 1'b0, 1'b1, 8'h5A);
    chk("R9", "wr a9 kind", cmdKind, 5);
    chk("R9", "wr a9 open", bankOpen, 1);
    chk("R9", "wr a9 lock", lockBusy, 0);
    chk("R9", "wr a9 strobe", colStrobe, 1);
  endtask

  task automatic t_other_bank;
    doCmd(P_ACT, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R11", "other act kind", cmdKind, 0);
    chk("R11", "other act err", cmdErr, 0);
    doCmd(P_PRE, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R11", "other pre keeps open", bankOpen, 1);
    doCmd(P_PRE, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R11", "pre all kind", cmdKind, 2);
    chk("R11", "pre all closes", bankOpen, 0);
    doCmd(P_PRE, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7", "pre idle err", cmdErr, 0);
    chk("R7", "pre idle stays", bankOpen, 0);
  endtask

  task automatic t_autopre;
    burstSel = 3'd2; // length 4, lockout TRP+4 = 6
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    idle(TRCD - 1);
    doCmd(P_RD, 1'b0, 1'b0, 1'b1, 8'h77);
    chk("R5", "rda kind", cmdKind, 4);
    chk("R5", "rda strobe", colStrobe, 1);
    chk("R5", "rda lock", lockBusy, 1);
    chk("R5", "rda closes", bankOpen, 0);
    idle(3);
    chk("R5", "lock held", lockBusy, 1);
    doCmd(P_PRE, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7", "pre in lock err", cmdErr, 1);
    chk("R5", "lock still", lockBusy, 1);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R5", "last locked edge err", cmdErr, 1);
    chk("R5", "lock ends", lockBusy, 0);
    chk("R5", "idle after lock", bankOpen, 0);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R5", "act after lock err", cmdErr, 0);
    chk("R5", "act after lock opens", bankOpen, 1);
    burstSel = 3'd0; // length 1, lockout 3
    idle(TRCD - 1);
    doCmd(P_RD, 1'b0, 1'b0, 1'b1, 8'h01);
    chk("R5", "bl1 lock", lockBusy, 1);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R5", "bl1 early 1", cmdErr, 1);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R5", "bl1 early 2", cmdErr, 1);
    doCmd(P_ACT, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R5", "bl1 on time", cmdErr, 0);
    chk("R5", "bl1 open", bankOpen, 1);
  endtask

  task automatic t_fullpage;
    burstSel = 3'd7;
    idle(TRCD - 1);
    doCmd(P_RD, 1'b0, 1'b0, 1'b1, 8'hF0);
    chk("R6", "fp strobe", colStrobe, 1);
    chk("R6", "fp open", bankOpen, 1);
    chk("R6", "fp no lock", lockBusy, 0);
    doCmd(P_WR, 1'b0, 1'b0, 1'b0, 8'h0F);
    chk("R6", "fp next err", cmdErr, 0);
    chk("R6", "fp next strobe", colStrobe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_decode;
    t_activate;
    t_rcd;
    t_read_write_a9;
    t_other_bank;
    t_autopre;
    t_fullpage;
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule